// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a host reach the internal registers of one or more Ethernet PHYs over the two-wire serial management interface. The host sees three word locations on a plain register bus. One holds a 32-bit frame word, one holds a clock divider, and one holds a sticky completion flag. Writing the frame word queues a management frame. The frame goes out as soon as the divider is non-zero. If the divider is still zero, the frame waits until a non-zero divider is written, so the host may program the two registers in either order.

Each frame is 64 MDC periods long. It carries 32 preamble ones and then the 32 bits of the frame word, most significant bit first. The block changes MDIO just after the falling edge of MDC and samples it on the rising edge. For a read, it releases MDIO from the second turnaround bit onward. The 16 bits returned by the PHY then replace the data field of the frame word. The register bus is plain control traffic, accepted in the cycle it is presented, so it has no valid/ready handshake and never applies back-pressure.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: With a non-zero divider, writing the frame word (address 0) starts a frame. The frame drives 32 ones and then frame bits 31 down to 0, one bit per MDC period.
- R2: A frame word written while the divider (address 1) is zero produces no MDC activity. A later write of a non-zero divider sends the held frame word unchanged.
- R3: MDC is low while idle and has a period of 2 × divider system clocks while a frame runs. MDIO output and output-enable change only after a falling MDC edge, and MDIO input is sampled on a rising MDC edge.
- R4: When the opcode field (frame bits 29:28) is 2'b10 (read), output-enable is low from overall bit 47 (the second turnaround bit, frame bit 16) through bit 63. For any other opcode, output-enable is high for all 64 bits.
- R5: After a read frame, the 16 bits sampled from the PHY, first bit in bit 15, replace frame bits 15:0. Frame bits 31:16 keep their values.
- R6: When the last bit ends, the completion flag (status address 2, bit 0) and the irq output go high and stay high. Writing 1 to status bit 0 clears the flag, and writing 0 leaves it set.
- R7: The frame word and the divider read back on bus_rdata at addresses 0 and 1. The divider is zero-extended.
- R8: Writes to the frame word while a frame is running are ignored.
- R9: After reset, MDC is 0, output-enable is 0, irq is 0 and the divider reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 frame, 1 divider, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |
| irq | output | 1 | Sticky frame-complete interrupt |

## Verification
The bench builds the block with a 4-bit divider, so the largest legal divider, 15, is reachable in a short run. Frames run with dividers of 1, 2, 3, 5 and 15. These cover a one-cycle half period, even and odd dividers, and the top of the range. A model PHY drives read data on falling MDC edges and records every bit, so preamble, frame bits, turnaround release and captured data are all compared bit by bit. Directed cases cover the held-frame path with a zero divider, writes during a running frame, and clearing the completion flag.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W    = 32;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int TOTAL_BITS = PRE_BITS + FRAME_W;
  localparam int CNT_W      = $clog2(TOTAL_BITS);
  localparam int OP_HI      = 29;
  localparam int OP_LO      = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int RELEASE_IDX = PRE_BITS + 15;
  localparam int RDATA_IDX   = PRE_BITS + 16;
  localparam logic [1:0] ADDR_FRAME = 2'd0;
  localparam logic [1:0] ADDR_DIV   = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div > 1 && tick) |=> !tick); // R3
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               tick,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done,
  output logic               is_read,
  output logic [DATA_W-1:0]  rd_data,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe
);
  localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(PRE_BITS);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TOTAL_BITS - 1);
  localparam logic [CNT_W-1:0] REL_C  = CNT_W'(RELEASE_IDX);
  localparam logic [CNT_W-1:0] RDAT_C = CNT_W'(RDATA_IDX);

  logic               busy_q, mdc_q, done_q, rd_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sreg_q;
  logic [DATA_W-1:0]  rdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
      sreg_q <= '0;
      rdat_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        mdc_q  <= 1'b0;
        cnt_q  <= '0;
        sreg_q <= frame_in;
        rd_q   <= (frame_in[OP_HI:OP_LO] == OP_READ);
      end else if (busy_q && tick) begin
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (rd_q && cnt_q >= RDAT_C) rdat_q <= {rdat_q[DATA_W-2:0], mdio_i};
        end else begin
          mdc_q <= 1'b0;
          if (cnt_q >= PRE_C) sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
          if (cnt_q == LAST_C) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign is_read = rd_q;
  assign rd_data = rdat_q;
  assign mdc     = mdc_q;
  assign mdio_o  = (!busy_q || cnt_q < PRE_C) ? 1'b1 : sreg_q[FRAME_W-1];
  assign mdio_oe = busy_q && !(rd_q && cnt_q >= REL_C);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc_q && !mdio_oe)); // R3
  AST_MDC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(mdc_q)); // R3
  AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mdc_q && !tick) |=> ($stable(mdio_o) && $stable(mdio_oe))); // R3
  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q < PRE_C) |-> (mdio_o && mdio_oe)); // R1
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && cnt_q >= RDAT_C) |-> !mdio_oe); // R4
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);
  logic [FRAME_W-1:0] frame_q;
  logic [DIV_W-1:0]   div_q, div_act_q;
  logic               pend_q, flag_q;
  logic               busy, done, is_read, tick, start;
  logic [DATA_W-1:0]  rd_data;

  logic wr_frame, wr_div, clr_flag;
  assign wr_frame = bus_wr && bus_addr == ADDR_FRAME && !busy;
  assign wr_div   = bus_wr && bus_addr == ADDR_DIV;
  assign clr_flag = bus_wr && bus_addr == ADDR_STAT && bus_wdata[0];
  assign start    = pend_q && (div_q != '0) && !busy;

  always_ff @(posedge clk) begin
    if (wr_frame)             frame_q <= bus_wdata;
    else if (done && is_read) frame_q[DATA_W-1:0] <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      div_act_q <= '0;
      pend_q    <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (wr_div)        div_q <= bus_wdata[DIV_W-1:0];
      if (start)         div_act_q <= div_q;
      if (wr_frame)      pend_q <= 1'b1;
      else if (start)    pend_q <= 1'b0;
      if (done)          flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_FRAME: bus_rdata = frame_q;
      ADDR_DIV:   bus_rdata = 32'(div_q);
      ADDR_STAT:  bus_rdata = {31'b0, flag_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = flag_q;

  mdio_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_act_q), .tick(tick)
  );

  mdio_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame_q),
    .tick(tick), .mdio_i(mdio_i), .busy(busy), .done(done),
    .is_read(is_read), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  AST_NO_START_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && !busy) |=> !busy); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_flag) |=> flag_q); // R6
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == ADDR_FRAME) |=> $stable(frame_q[FRAME_W-1:DATA_W])); // R8
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;
  localparam int DIV_W = 4;
  localparam int NVEC  = 5;
  // {divider, frame word, PHY read data}
  localparam logic [51:0] VEC [NVEC] = '{
    {4'd1,  32'h5196A5C3, 16'h0000},
    {4'd3,  32'h68880000, 16'h3C5A},
    {4'd2,  32'h68881234, 16'hFFFF},
    {4'd5,  32'h5FFF0001, 16'h0000},
    {4'd15, 32'h6888FFFF, 16'h8001}
  };

  logic clk = 0, rst_n = 0, bus_wr = 0, mdio_i = 1;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mdio_mgmt_ctrl #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // model PHY: records each bit at rising MDC, drives read data after falling MDC
  task automatic phy_run(input logic [15:0] rd, output logic [63:0] bits,
                         output logic [63:0] oes, output realtime per);
    realtime t0;
    t0 = 0; per = 0;
    mdio_i = 1;
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      if (k == 0) t0 = $realtime;
      if (k == 1) per = $realtime - t0;
      #1;
      bits[63-k] = mdio_o;
      oes[63-k]  = mdio_oe;
      @(negedge mdc);
      #1;
      mdio_i = (k + 1 >= 48 && k + 1 < 64) ? rd[63-(k+1)] : 1'b1;
    end
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [63:0] bits, oes, exp_oe;
    realtime per;
    logic [31:0] fr, expf;
    logic [3:0] dv;
    logic [15:0] rd;
    bit is_rd;

    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 mdc", 64'(mdc), 64'd0);
    chk("R9 oe", 64'(mdio_oe), 64'd0);
    chk("R9 irq", 64'(irq), 64'd0);
    rst_n = 1;
    bus_read(2'd1, rv);
    chk("R9 div", 64'(rv), 64'd0);

    for (int v = 0; v < NVEC; v++) begin
      {dv, fr, rd} = VEC[v];
      is_rd = (fr[29:28] == 2'b10);
      bus_write(2'd1, 32'(dv));
      bus_read(2'd1, rv);
      chk("R7 div readback", 64'(rv), 64'(dv));
      bus_write(2'd0, fr);
      phy_run(rd, bits, oes, per);
      exp_oe = is_rd ? {{47{1'b1}}, 17'b0} : {64{1'b1}};
      chk("R4 oe pattern", oes, exp_oe);
      chk("R1 frame bits", bits & exp_oe, {32'hFFFFFFFF, fr} & exp_oe);
      chk("R3 mdc period", 64'(int'(per)), 64'(2 * dv * 8));
      repeat (2) @(negedge clk);
      chk("R6 irq set", 64'(irq), 64'd1);
      chk("R3 mdc idle", 64'(mdc), 64'd0);
      expf = is_rd ? {fr[31:16], rd} : fr;
      bus_read(2'd0, rv);
      chk(is_rd ? "R5 read data" : "R7 frame readback", 64'(rv), 64'(expf));
      bus_write(2'd2, 32'd0);
      chk("R6 write 0 keeps", 64'(irq), 64'd1);
      bus_write(2'd2, 32'd1);
      chk("R6 clear", 64'(irq), 64'd0);
    end

    // R2: hold frame while divider is zero
    bus_write(2'd1, 32'd0);
    bus_write(2'd0, 32'h5123ABCD);
    repeat (100) begin
      @(negedge clk);
      if (mdc) break;
    end
    chk("R2 no mdc when div 0", 64'(mdc), 64'd0);
    chk("R2 no irq when div 0", 64'(irq), 64'd0);
    bus_write(2'd1, 32'd2);
    phy_run(16'h0, bits, oes, per);
    chk("R2 held frame sent", bits, {32'hFFFFFFFF, 32'h5123ABCD});
    repeat (2) @(negedge clk);
    chk("R2 irq after held", 64'(irq), 64'd1);
    bus_write(2'd2, 32'd1);

    // R8: writes while busy ignored
    bus_write(2'd1, 32'd3);
    bus_write(2'd0, 32'h5ACE0F0F);
    repeat (20) @(negedge clk);
    bus_write(2'd0, 32'h50001111);
    wait_irq(2000);
    chk("R8 irq", 64'(irq), 64'd1);
    bus_read(2'd0, rv);
    chk("R8 busy write ignored", 64'(rv), 64'h5ACE0F0F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule